// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel data ports, A and B, and keeps one storage register for each direction. Each port has its own input, output and output-enable signals rather than a true tri-state pin, so the pad ring or bus fabric outside the block combines them. An active-low output enable and a direction select pick which port, if either, is driven. For each direction, a separate select chooses whether the driving port carries the live data from the other port or the word held in that direction's register.

Capture is qualified by the system clock. When a capture strobe is high at a rising clock edge, the matching register samples its own port's input. Capture works whatever the output enable and direction inputs are set to. A word can therefore be stored while the block is isolated and driven out later. In stored mode, a word captured at an edge reaches the far port directly after that edge, so capture and forward take a single operation. A synchronous active-high reset clears both registers.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A clock edge with `rst` high clears both storage registers to zero; after reset, stored mode drives zero on either port.
- R2: A clock edge with `cap_a` high and `rst` low loads `a_in` into the A register. A clock edge with `cap_a` low leaves the A register unchanged.
- R3: A clock edge with `cap_b` high and `rst` low loads `b_in` into the B register. A clock edge with `cap_b` low leaves the B register unchanged.
- R4: Capture takes place for every value of `oe_n`, `dir` and the two selects, isolation included.
- R5: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R6: While `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0.
- R7: While `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0.
- R8: While `b_oe` is 1, `b_out` equals `a_in` when `sel_a2b` is 0, and equals the A register when `sel_a2b` is 1.
- R9: While `a_oe` is 1, `a_out` equals `b_in` when `sel_b2a` is 0, and equals the B register when `sel_b2a` is 1.
- R10: In stored mode, a word captured at a clock edge appears on the driving port's output right after that edge, with no extra cycle.
- R11: `a_oe` and `b_oe` are never both 1.
- R12: A port whose output enable is 0 presents all zeros on its output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; registers capture on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | Direction: 1 drives port B, 0 drives port A |
| sel_a2b | input | 1 | Source for port B: 0 live A data, 1 stored A word |
| sel_b2a | input | 1 | Source for port A: 0 live B data, 1 stored B word |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| a_in | input | WIDTH | Data received on port A |
| a_out | output | WIDTH | Data driven onto port A |
| a_oe | output | 1 | Port A output enable |
| b_in | input | WIDTH | Data received on port B |
| b_out | output | WIDTH | Data driven onto port B |
| b_oe | output | 1 | Port B output enable |

## Verification
The bench builds the block with its default WIDTH of 8. At this width, random words hit a wide spread of bit patterns, and live and stored data seldom match by chance, so a swapped source select shows up quickly. A directed sweep covers all sixteen settings of enable, direction and the two selects. Random cycles mix capture strobes with every control setting, which reaches capture during isolation and capture-and-forward on the same edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE  = 2'b00,
    DRV_PORTA = 2'b01,
    DRV_PORTB = 2'b10
  } drive_e;
endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_port_ctl.sv
module xcvr_port_ctl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  drive_e drv;

  always_comb begin
    if (oe_n)     drv = DRV_NONE;
    else if (dir) drv = DRV_PORTB;
    else          drv = DRV_PORTA;
  end

  assign a_oe = (drv == DRV_PORTA);
  assign b_oe = (drv == DRV_PORTB);
endmodule

// File: rtl/xcvr_out_sel.sv
module xcvr_out_sel #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    if (!en)             dout = '0;
    else if (use_stored) dout = stored;
    else                 dout = live;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] reg_a;
  logic [WIDTH-1:0] reg_b;

  xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold_a (
    .clk(clk), .rst(rst), .load(cap_a), .d(a_in), .q(reg_a)
  );

  xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold_b (
    .clk(clk), .rst(rst), .load(cap_b), .d(b_in), .q(reg_b)
  );

  xcvr_port_ctl u_ctl (
    .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
  );

  xcvr_out_sel #(.WIDTH(WIDTH)) u_sel_to_b (
    .en(b_oe), .use_stored(sel_a2b), .live(a_in), .stored(reg_a), .dout(b_out)
  );

  xcvr_out_sel #(.WIDTH(WIDTH)) u_sel_to_a (
    .en(a_oe), .use_stored(sel_b2a), .live(b_in), .stored(reg_b), .dout(a_out)
  );
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_a2b,
  input logic             sel_b2a,
  input logic             cap_a,
  input logic             cap_b,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe
);
  assert_one_driver_R11: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  assert_isolate_R5: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe));

  assert_drive_b_R6: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir) |-> (b_oe && !a_oe));

  assert_drive_a_R7: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir) |-> (a_oe && !b_oe));

  assert_quiet_a_R12: assert property (@(posedge clk) disable iff (rst)
    !a_oe |-> (a_out == '0));

  assert_quiet_b_R12: assert property (@(posedge clk) disable iff (rst)
    !b_oe |-> (b_out == '0));

  assert_live_b_R8: assert property (@(posedge clk) disable iff (rst)
    (b_oe && !sel_a2b) |-> (b_out == a_in));

  assert_live_a_R9: assert property (@(posedge clk) disable iff (rst)
    (a_oe && !sel_b2a) |-> (a_out == b_in));

  // R2, R10: a captured A word is forwarded to B after the edge
  assert_fwd_a_R2: assert property (@(posedge clk) disable iff (rst)
    cap_a |=> ((b_oe && sel_a2b) ? (b_out == $past(a_in)) : 1'b1));

  // R3, R10: a captured B word is forwarded to A after the edge
  assert_fwd_b_R3: assert property (@(posedge clk) disable iff (rst)
    cap_b |=> ((a_oe && sel_b2a) ? (a_out == $past(b_in)) : 1'b1));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         oe_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic         cap_a = 1'b0, cap_b = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  logic [W-1:0] m_a = '0, m_b = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) u_bus_xcvr_reg (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic exp_a_oe(logic on, logic d);
    return !on && !d;
  endfunction

  function automatic logic exp_b_oe(logic on, logic d);
    return !on && d;
  endfunction

  function automatic logic [W-1:0] exp_out(logic en, logic st,
                                           logic [W-1:0] live, logic [W-1:0] held);
    if (!en) return '0;
    return st ? held : live;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare all outputs with the model; tag names the requirement
  task automatic check_all(string tag);
    logic ea, eb;
    ea = exp_a_oe(oe_n, dir);
    eb = exp_b_oe(oe_n, dir);
    chk({tag, " R11 one driver"}, W'(a_oe & b_oe), W'(0));
    if (oe_n) begin
      chk({tag, " R5 a_oe"}, W'(a_oe), W'(ea));
      chk({tag, " R5 b_oe"}, W'(b_oe), W'(eb));
    end else if (dir) begin
      chk({tag, " R6 b_oe"}, W'(b_oe), W'(eb));
      chk({tag, " R6 a_oe"}, W'(a_oe), W'(ea));
    end else begin
      chk({tag, " R7 a_oe"}, W'(a_oe), W'(ea));
      chk({tag, " R7 b_oe"}, W'(b_oe), W'(eb));
    end
    if (eb) chk({tag, " R8 b_out"}, b_out, exp_out(1'b1, sel_a2b, a_in, m_a));
    else    chk({tag, " R12 b_out"}, b_out, '0);
    if (ea) chk({tag, " R9 a_out"}, a_out, exp_out(1'b1, sel_b2a, b_in, m_b));
    else    chk({tag, " R12 a_out"}, a_out, '0);
  endtask

  // drive after falling edge, check, then take the rising edge
  task automatic cyc(string tag, logic on, logic d, logic sab, logic sba,
                     logic ca, logic cb, logic [W-1:0] ai, logic [W-1:0] bi);
    oe_n = on; dir = d; sel_a2b = sab; sel_b2a = sba;
    cap_a = ca; cap_b = cb; a_in = ai; b_in = bi;
    #2;
    check_all(tag);
    @(posedge clk);
    if (rst) begin
      m_a = '0; m_b = '0;
    end else begin
      if (ca) m_a = ai;
      if (cb) m_b = bi;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // reset, with capture attempts that reset must override
    cyc("rst", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55);
    cyc("rst", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hC3);
    rst = 1'b0;
    // R1: stored mode shows zero on both ports after reset
    cyc("R1 stored B", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
    chk("R1 b_out after reset", b_out, 8'h00);
    cyc("R1 stored A", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
    chk("R1 a_out after reset", a_out, 8'h00);

    // R4: capture in isolation, then drive the stored words out
    cyc("R4 iso cap", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hA7);
    cyc("R2 hold", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22);
    cyc("R2 out", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33, 8'h44);
    chk("R2 R4 stored A on b_out", b_out, 8'h5A);
    cyc("R3 out", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h66, 8'h77);
    chk("R3 R4 stored B on a_out", a_out, 8'hA7);

    // every control combination with fixed stored words
    for (int k = 0; k < 16; k++)
      cyc("sweep", k[3], k[2], k[1], k[0], 1'b0, 1'b0, 8'hC9, 8'h36);

    // R10: capture and forward on the same edge, stored mode
    cyc("R10 cap", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE1, 8'h00);
    cyc("R10 next", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h00);
    chk("R10 forwarded A word", b_out, 8'hE1);
    cyc("R10 cap", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h9D);
    cyc("R10 next", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01);
    chk("R10 forwarded B word", a_out, 8'h9D);

    // random mix of controls, strobes and data
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ctl;
      ctl = 8'($urandom);
      cyc("rand", ctl[0], ctl[1], ctl[2], ctl[3], ctl[4], ctl[5],
          W'($urandom), W'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule